// File: doc/BRIEF.md
# Hot-plug Interrupt Locator Aggregator

This block gathers the interrupt sources of a hot-plug controller into one place. Each slot owns a small latch of event bits, set by dedicated pulse inputs from the event sources, together with a read-write mask that hides chosen events. A controller-wide flag records that a slot command has finished. The block folds all of this into a locator word. Bit 0 of that word stands for the command flag, and bit s+1 stands for slot s, so software can see at a glance which sources are pending. The same folded value gives one interrupt level.

A global control word carries four disable bits, which are set at reset, and two sticky detection flags that software clears by writing ones. The interrupt is delivered in one of two ways. In wired mode the registered level is driven on `irq`. In message mode a single-cycle `msi_pulse` is raised whenever the computed level differs from the level last signalled. A `restore` pulse forgets the last signalled level, so that any events still pending are signalled again.

Register words are addressed by word index. Word 0 is the global word: disables in [3:0], command-detected in bit 16, arbiter-detected in bit 17. Word 1 is the read-only locator. Word 2+s belongs to slot s: event latch in [4:0] and disable mask in [14:8]. All other words read as zero.

Top module: `hpi_locator_agg`

## Requirements
- R1: After reset the global word reads 0x0000000F, every slot word reads 0x00007F00, the locator is 0, and `irq` and `msi_pulse` are low.
- R2: A one-cycle pulse on `evt_set[s*5+b]` sets bit b of slot s's latch (0 presence, 1 isolated fault, 2 attention button, 3 retention latch, 4 connected fault), and the latch is readable in bits [4:0] of word 2+s.
- R3: Writing a 1 to bit b in [4:0] of a slot word clears that latch bit, and writing 0 leaves it unchanged. If an event set and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R4: Bits [14:8] of a slot word are a read-write 7-bit disable mask. Only mask bits [12:8] (mask bits 0..4) gate the matching event bits; mask bits 5 and 6 are stored but gate nothing.
- R5: Locator bit s+1 is 1 exactly when slot s has a latched event whose mask bit is clear. The locator appears on `locator` and in word 1.
- R6: Locator bit 0 is 1 exactly when command-detected (word 0 bit 16) is set and command-interrupt-disable (word 0 bit 2) is clear. A `cmd_done` pulse sets command-detected, writing 1 to bit 16 clears it, and bits [3:0] of word 0 are plain read-write.
- R7: An `arb_done` pulse sets word 0 bit 17, and writing 1 to that bit clears it. This bit never affects the locator or the interrupt.
- R8: The computed level is high when global disable bit 0 is clear and the locator is nonzero. With `msi_mode` low, `irq` shows that level one clock after the register write or event input that changed it. With `msi_mode` high, `irq` stays low.
- R9: With `msi_mode` high, `msi_pulse` is high for one cycle, one clock after the computed level comes to differ from the last signalled level. This applies to both rising and falling changes.
- R10: A `restore` pulse forces the last signalled level to 0. If the computed level is still high, one new `msi_pulse` follows one cycle later.
- R11: The locator word and any word past the last slot cannot be written. Words past the last slot read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word index of the read |
| rd_data | output | 32 | Read data, combinational |
| evt_set | input | NUM_SLOTS*5 | Per-slot event set pulses |
| cmd_done | input | 1 | Sets command-detected |
| arb_done | input | 1 | Sets arbiter-detected |
| msi_mode | input | 1 | 1 selects message-pulse delivery |
| restore | input | 1 | Forces last signalled level to 0 |
| locator | output | NUM_SLOTS+1 | Interrupt locator |
| irq | output | 1 | Wired interrupt level |
| msi_pulse | output | 1 | Message interrupt request pulse |

## Verification
Three pairs of functions can land on the same clock edge. An event source can set a latch bit while software writes one to clear that same bit. A write to the disable bits can coincide with a write-one-clear of command-detected, because both live in the same word. A restore can arrive while the level is high. The bench drives each pair from one falling edge so that both act on the same rising edge. It then judges the result from the readback word, the locator and the pulse timing: the bit must stay set, the disable must take effect while the flag clears, and exactly one fresh pulse must follow the restore.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
   // Per-slot event latch layout (decoded by the event sources)
   localparam int EVT_W        = 5;
   localparam int EVT_PRESENCE = 0;
   localparam int EVT_ISO_FLT  = 1;
   localparam int EVT_BUTTON   = 2;
   localparam int EVT_RETAIN   = 3;
   localparam int EVT_CONN_FLT = 4;

   // Per-slot disable mask: 5 gating bits plus two error-only bits
   localparam int DIS_W        = 7;
   localparam int DIS_LSB      = 8;

   // Global word fields
   localparam int GDIS_W       = 4;
   localparam int GDIS_IRQ     = 0;
   localparam int GDIS_CMD     = 2;
   localparam int CMD_DET_BIT  = 16;
   localparam int ARB_DET_BIT  = 17;

   // Word map
   localparam int WORD_GLOBAL  = 0;
   localparam int WORD_LOC     = 1;
   localparam int WORD_SLOT0   = 2;

   localparam int MIN_SLOTS    = 1;
   localparam int MAX_SLOTS    = 31;

   localparam logic [GDIS_W-1:0] GDIS_RESET = '1;
   localparam logic [DIS_W-1:0]  DIS_RESET  = '1;
endpackage

// File: rtl/hpi_slot_latch.sv
module hpi_slot_latch
   import hpi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_i,
   input  logic             wr_i,
   input  logic [EVT_W-1:0] clr_i,
   input  logic [DIS_W-1:0] dis_wdata_i,
   output logic [EVT_W-1:0] lat_o,
   output logic [DIS_W-1:0] dis_o,
   output logic             pend_o
);
   logic [EVT_W-1:0] clr_eff;

   assign clr_eff = wr_i ? clr_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_o <= '0;
         dis_o <= DIS_RESET;
      end else begin
         // set has priority over a same-cycle write-one-clear
         lat_o <= (lat_o & ~clr_eff) | set_i;
         if (wr_i) dis_o <= dis_wdata_i;
      end
   end

   // only the low EVT_W mask bits gate events
   assign pend_o = |(lat_o & ~dis_o[EVT_W-1:0]);
endmodule

// File: rtl/hpi_global_ctl.sv
module hpi_global_ctl
   import hpi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [GDIS_W-1:0] gdis_wdata_i,
   input  logic              cmd_clr_i,
   input  logic              arb_clr_i,
   input  logic              cmd_set_i,
   input  logic              arb_set_i,
   output logic [GDIS_W-1:0] gdis_o,
   output logic              cmd_det_o,
   output logic              arb_det_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gdis_o    <= GDIS_RESET;
         cmd_det_o <= 1'b0;
         arb_det_o <= 1'b0;
      end else begin
         if (wr_i) gdis_o <= gdis_wdata_i;
         cmd_det_o <= (cmd_det_o & ~(wr_i & cmd_clr_i)) | cmd_set_i;
         arb_det_o <= (arb_det_o & ~(wr_i & arb_clr_i)) | arb_set_i;
      end
   end
endmodule

// File: rtl/hpi_notify.sv
module hpi_notify (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic msi_mode_i,
   input  logic restore_i,
   output logic irq_o,
   output logic msi_pulse_o
);
   logic req_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_lvl     <= 1'b0;
         msi_pulse_o <= 1'b0;
      end else if (restore_i) begin
         req_lvl     <= 1'b0;
         msi_pulse_o <= 1'b0;
      end else begin
         req_lvl     <= level_i;
         msi_pulse_o <= msi_mode_i & (level_i != req_lvl);
      end
   end

   assign irq_o = req_lvl & ~msi_mode_i;
endmodule

// File: rtl/hpi_locator_agg.sv
module hpi_locator_agg
   import hpi_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int ADDR_W    = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [31:0]                wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [31:0]                rd_data,
   input  logic [NUM_SLOTS*EVT_W-1:0] evt_set,
   input  logic                       cmd_done,
   input  logic                       arb_done,
   input  logic                       msi_mode,
   input  logic                       restore,
   output logic [NUM_SLOTS:0]         locator,
   output logic                       irq,
   output logic                       msi_pulse
);
   localparam int LAT_W     = NUM_SLOTS * EVT_W;
   localparam int LAST_WORD = WORD_SLOT0 + NUM_SLOTS - 1;

   if (NUM_SLOTS < MIN_SLOTS || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("hpi_locator_agg: NUM_SLOTS out of range");
   end
   if (LAST_WORD >= (1 << ADDR_W)) begin : g_bad_addr
      $error("hpi_locator_agg: ADDR_W too small for NUM_SLOTS");
   end

   logic [EVT_W-1:0]  lat   [NUM_SLOTS];
   logic [DIS_W-1:0]  dis   [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] pend;
   logic [NUM_SLOTS-1:0] slot_wr;
   logic [LAT_W-1:0]  lat_flat;
   logic [GDIS_W-1:0] gdis;
   logic              cmd_det;
   logic              arb_det;
   logic              glob_wr;
   logic              level;
   wire unused_wr_bits = ^{wr_data[31:18], wr_data[15], wr_data[7:5]};

   assign glob_wr = wr_en && (wr_addr == ADDR_W'(WORD_GLOBAL));

   hpi_global_ctl u_glob (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (glob_wr),
      .gdis_wdata_i (wr_data[GDIS_W-1:0]),
      .cmd_clr_i    (wr_data[CMD_DET_BIT]),
      .arb_clr_i    (wr_data[ARB_DET_BIT]),
      .cmd_set_i    (cmd_done),
      .arb_set_i    (arb_done),
      .gdis_o       (gdis),
      .cmd_det_o    (cmd_det),
      .arb_det_o    (arb_det)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_wr[s] = wr_en && (wr_addr == ADDR_W'(WORD_SLOT0 + s));

      hpi_slot_latch u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .set_i       (evt_set[s*EVT_W +: EVT_W]),
         .wr_i        (slot_wr[s]),
         .clr_i       (wr_data[EVT_W-1:0]),
         .dis_wdata_i (wr_data[DIS_LSB +: DIS_W]),
         .lat_o       (lat[s]),
         .dis_o       (dis[s]),
         .pend_o      (pend[s])
      );

      assign lat_flat[s*EVT_W +: EVT_W] = lat[s];
      assign locator[s+1]               = pend[s];
   end

   assign locator[0] = cmd_det & ~gdis[GDIS_CMD];
   assign level      = ~gdis[GDIS_IRQ] & (|locator);

   hpi_notify u_notify (
      .clk         (clk),
      .rst_n       (rst_n),
      .level_i     (level),
      .msi_mode_i  (msi_mode),
      .restore_i   (restore),
      .irq_o       (irq),
      .msi_pulse_o (msi_pulse)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(WORD_GLOBAL)) begin
         rd_data[GDIS_W-1:0]  = gdis;
         rd_data[CMD_DET_BIT] = cmd_det;
         rd_data[ARB_DET_BIT] = arb_det;
      end else if (rd_addr == ADDR_W'(WORD_LOC)) begin
         rd_data = 32'(locator);
      end else begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_addr == ADDR_W'(WORD_SLOT0 + s)) begin
               rd_data[EVT_W-1:0]        = lat[s];
               rd_data[DIS_LSB +: DIS_W] = dis[s];
            end
         end
      end
   end
endmodule

// File: rtl/hpi_locator_agg_chk.sv
module hpi_locator_agg_chk
   import hpi_pkg::*;
#(
   parameter int NUM_SLOTS = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_SLOTS*EVT_W-1:0] evt_set,
   input logic                       msi_mode,
   input logic [NUM_SLOTS:0]         locator,
   input logic                       irq,
   input logic                       msi_pulse,
   input logic                       cmd_det,
   input logic [NUM_SLOTS*EVT_W-1:0] lat_flat
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R3: a set pulse always lands, even against a same-cycle clear
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (|evt_set) |=> ((lat_flat & $past(evt_set)) == $past(evt_set)));

   // R5: a slot locator bit needs a latched event in that slot
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_loc
      a_r5_loc_has_event: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         locator[s+1] |-> (|lat_flat[s*EVT_W +: EVT_W]));
   end

   // R6: locator bit 0 needs the command flag
   a_r6_cmd_loc: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      locator[0] |-> cmd_det);

   // R8: wired level only follows a nonzero locator, and only in wired mode
   a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq |-> ($past(|locator) && !msi_mode));

   // R9: message pulses only come from message mode
   a_r9_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      msi_pulse |-> $past(msi_mode));
endmodule

bind hpi_locator_agg hpi_locator_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_set   (evt_set),
   .msi_mode  (msi_mode),
   .locator   (locator),
   .irq       (irq),
   .msi_pulse (msi_pulse),
   .cmd_det   (cmd_det),
   .lat_flat  (lat_flat)
);

// File: tb/hpi_locator_agg_tb.sv
module hpi_locator_agg_tb;
   localparam int NS = 4;
   localparam int AW = 5;
   localparam int EW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [31:0]     rd_data;
   logic [NS*EW-1:0] evt_set = '0;
   logic            cmd_done = 1'b0;
   logic            arb_done = 1'b0;
   logic            msi_mode = 1'b0;
   logic            restore = 1'b0;
   logic [NS:0]     locator;
   logic            irq;
   logic            msi_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   hpi_locator_agg #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_set(evt_set), .cmd_done(cmd_done), .arb_done(arb_done),
      .msi_mode(msi_mode), .restore(restore), .locator(locator),
      .irq(irq), .msi_pulse(msi_pulse)
   );

   typedef struct packed {
      logic [1:0]  op;    // 0 write, 1 event pulse, 2 command-done pulse
      logic [4:0]  addr;
      logic [31:0] data;
      logic [4:0]  loc;
      logic        irq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 5'd0, 32'h0000_0000, 5'h00, 1'b0},  // R6 enable all
      '{2'd1, 5'd0, 32'h0000_0080, 5'h00, 1'b0},  // R4 slot1 button, masked
      '{2'd0, 5'd3, 32'h0000_7B00, 5'h04, 1'b1},  // R5 unmask button
      '{2'd0, 5'd3, 32'h0000_7B04, 5'h00, 1'b0},  // R3 clear button
      '{2'd2, 5'd0, 32'h0000_0000, 5'h01, 1'b1},  // R6 command done
      '{2'd0, 5'd0, 32'h0000_0004, 5'h00, 1'b0},  // R6 cmd int disabled
      '{2'd0, 5'd0, 32'h0000_0000, 5'h01, 1'b1},  // R6 re-enabled
      '{2'd0, 5'd0, 32'h0000_0001, 5'h01, 1'b0},  // R8 global disable
      '{2'd0, 5'd0, 32'h0001_0000, 5'h00, 1'b0},  // R6 w1c cmd + enable
      '{2'd1, 5'd0, 32'h0000_8000, 5'h00, 1'b0},  // R2 slot3 presence masked
      '{2'd0, 5'd5, 32'h0000_7E00, 5'h10, 1'b1},  // R5 slot3 unmasked
      '{2'd1, 5'd0, 32'h0000_0010, 5'h10, 1'b1},  // R4 slot0 conn fault masked
      '{2'd0, 5'd2, 32'h0000_6F00, 5'h12, 1'b1},  // R5 slot0 unmasked
      '{2'd0, 5'd5, 32'h0000_7E01, 5'h02, 1'b1},  // R3 clear slot3
      '{2'd0, 5'd2, 32'h0000_6F10, 5'h00, 1'b0}   // R3 clear slot0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_check(input string req, input int addr, input logic [31:0] exp);
      rd_addr = AW'(addr);
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic do_write(input int addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_event(input logic [NS*EW-1:0] v);
      @(negedge clk);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic do_cmd();
      @(negedge clk);
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_check("R1 global", 0, 32'h0000_000F);
      for (int s = 0; s < NS; s++) rd_check("R1 slot", 2 + s, 32'h0000_7F00);
      check("R1 locator", 32'(locator), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      check("R1 pulse", 32'(msi_pulse), 32'h0);

      // table walk, wired mode
      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            2'd0: do_write(int'(VECS[i].addr), VECS[i].data);
            2'd1: do_event(VECS[i].data[NS*EW-1:0]);
            default: do_cmd();
         endcase
         check($sformatf("R5 vec %0d locator", i), 32'(locator), 32'(VECS[i].loc));
         @(negedge clk);
         check($sformatf("R8 vec %0d irq", i), 32'(irq), 32'(VECS[i].irq));
      end

      // R8 timing: irq follows one clock after the event lands
      do_event(20'h0_0080);           // slot1 button, unmasked (0x7B)
      check("R8 irq not yet", 32'(irq), 32'h0);
      check("R5 locator word", 32'(locator), 32'h4);
      rd_check("R5 word1", 1, 32'h0000_0004);
      @(negedge clk);
      check("R8 irq one clock later", 32'(irq), 32'h1);
      do_write(3, 32'h0000_7B04);
      @(negedge clk);
      check("R8 irq drops", 32'(irq), 32'h0);

      // R3 set wins over same-cycle clear (slot2 isolated fault)
      @(negedge clk);
      evt_set = 20'h0_0800;
      wr_en = 1'b1; wr_addr = AW'(4); wr_data = 32'h0000_7F02;
      @(negedge clk);
      evt_set = '0; wr_en = 1'b0;
      rd_check("R3 set beats clear", 4, 32'h0000_7F02);
      do_write(4, 32'h0000_7F02);
      rd_check("R3 w1c alone", 4, 32'h0000_7F00);

      // R4 mask bits 5,6 do not gate events
      do_event(20'h0_2000);           // slot2 retention latch
      do_write(4, 32'h0000_6000);
      rd_check("R4 mask readback", 4, 32'h0000_6008);
      check("R4 upper mask ignored", 32'(locator), 32'h8);
      do_write(4, 32'h0000_7F08);
      check("R4 cleared", 32'(locator), 32'h0);

      // R7 arbiter flag
      @(negedge clk); arb_done = 1'b1;
      @(negedge clk); arb_done = 1'b0;
      rd_check("R7 arb set", 0, 32'h0002_0000);
      check("R7 no locator", 32'(locator), 32'h0);
      @(negedge clk);
      check("R7 no irq", 32'(irq), 32'h0);
      do_write(0, 32'h0002_0000);
      rd_check("R7 arb clear", 0, 32'h0000_0000);

      // R6 disable write and cmd clear in the same word/cycle
      do_cmd();
      do_write(0, 32'h0001_0004);
      rd_check("R6 combined write", 0, 32'h0000_0004);
      do_write(0, 32'h0000_0000);

      // R9 message mode rising
      msi_mode = 1'b1;
      do_event(20'h0_0080);
      check("R9 no pulse yet", 32'(msi_pulse), 32'h0);
      @(negedge clk);
      check("R9 rise pulse", 32'(msi_pulse), 32'h1);
      check("R8 irq off in msi", 32'(irq), 32'h0);
      @(negedge clk);
      check("R9 single pulse", 32'(msi_pulse), 32'h0);

      // R10 restore re-signals pending level
      @(negedge clk); restore = 1'b1;
      @(negedge clk); restore = 1'b0;
      check("R10 quiet on restore", 32'(msi_pulse), 32'h0);
      @(negedge clk);
      check("R10 re-signal", 32'(msi_pulse), 32'h1);
      @(negedge clk);
      check("R10 single", 32'(msi_pulse), 32'h0);

      // R9 falling change also signals
      do_write(3, 32'h0000_7B04);
      @(negedge clk);
      check("R9 fall pulse", 32'(msi_pulse), 32'h1);
      @(negedge clk);
      check("R9 fall single", 32'(msi_pulse), 32'h0);
      msi_mode = 1'b0;

      // R11 read-only and unused words
      do_write(1, 32'hFFFF_FFFF);
      rd_check("R11 locator not writable", 1, 32'h0);
      do_write(2 + NS, 32'hFFFF_FFFF);
      rd_check("R11 beyond slots", 2 + NS, 32'h0);
      rd_check("R11 top word", 31, 32'h0);
      @(negedge clk);
      check("R11 no irq", 32'(irq), 32'h0);

      finish_run();
   end
endmodule